// File: doc/BRIEF.md
# Bit-Sliced Flit Queue with Redundant-Word Lane Gating

This block is an eight-entry first-in first-out queue for 128-bit network flits. Its storage is cut into four 32-bit lanes. Each lane has its own write enable and read enable, so each lane can be switched off on its own. Lane 0 holds bits 31:0. Lane 3 holds bits 127:96.

When a flit is accepted, detectors look at the three upper words. If all of them are zero, the flit is short and only lane 0 is written. If all of them are ones, the flit is also short and only lane 0 is written. A two-bit fill tag is stored with every entry. When the entry is read, only lane 0 is read, and the upper words are rebuilt from the tag.

Flits enter through a valid/ready write port and leave through a valid/ready read port. The read port is fed by a registered output stage. Two lane-enable vectors show which lanes are active in each cycle, so a power estimate can count the accesses that were gated.

Top module: `lane_buffer`

## Requirements
- R1: While reset is high, and in the first cycle after it, rd_valid is 0, wr_ready is 1, and both lane-enable vectors are 0.
- R2: Flits leave in the order they were accepted, and every flit comes out bit-exact.
- R3: A flit whose bits 127:32 are all zero is stored with lane 0 only. In its accept cycle wr_lane_en is 4'b0001, and on read its upper 96 bits are rebuilt as zeros.
- R4: A flit whose bits 127:32 are all ones is stored with lane 0 only. In its accept cycle wr_lane_en is 4'b0001, and on read its upper 96 bits are rebuilt as ones.
- R5: Any other flit writes all four lanes. In its accept cycle wr_lane_en is 4'b1111. In a cycle with no accepted write, wr_lane_en is 4'b0000.
- R6: In a cycle where the head stored entry moves into the output stage, rd_lane_en is 4'b0001 for a short entry and 4'b1111 for a full entry. In every other cycle rd_lane_en is 4'b0000. The move happens when storage is not empty and the output stage is empty or is being read in that cycle.
- R7: At most 8 flits wait in storage behind the output stage. With the reader stalled, exactly 9 flits are accepted. wr_ready then stays low, and wr_valid has no effect.
- R8: While rd_valid is high and rd_ready is low, rd_valid and rd_data stay unchanged on the next cycle.
- R9: A flit accepted at clock edge k into an empty queue makes rd_valid rise at edge k+1, and not before.
- R10: A flit whose upper words mix zero words, all-ones words and other words is treated as full. An example is upper words 0, FFFFFFFF, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write flit offered |
| wr_ready | output | 1 | Storage can accept a flit |
| wr_data | input | 128 | Incoming flit |
| rd_valid | output | 1 | Output stage holds a flit |
| rd_ready | input | 1 | Consumer takes the flit |
| rd_data | output | 128 | Outgoing flit |
| wr_lane_en | output | 4 | Lanes written this cycle |
| rd_lane_en | output | 4 | Lanes read this cycle |

## Verification
The bench sends all-zero-upper flits, all-ones-upper flits, mixed-upper flits and arbitrary flits. A design that mixed up the two short kinds would return ones where zeros belong. A design that tested only the first upper word would gate a mixed flit and corrupt it.

A stalled reader fills the queue to exactly nine flits. A counter that is off by one would either drop a flit or accept a tenth. The bench also holds rd_ready low while rd_valid is high, which catches an output stage that moves on too early.

For every cycle, the bench predicts whether a load should happen and with which lane pattern. A read enable that fired while the output stage was stalled would show up as an unexpected lane pattern.

// File: rtl/lanebuf_pkg.sv
package lanebuf_pkg;
    localparam int FLIT_W = 128;
    localparam int N_LANE = 4;
    localparam int DEPTH  = 8;

    typedef enum logic [1:0] {
        FILL_FULL = 2'd0,
        FILL_ZERO = 2'd1,
        FILL_ONES = 2'd2
    } fill_e;

    function automatic fill_e pick_fill(input logic upper_zero, input logic upper_ones);
        if (upper_zero)      return FILL_ZERO;
        else if (upper_ones) return FILL_ONES;
        else                 return FILL_FULL;
    endfunction
endpackage

// File: rtl/lane_detect.sv
module lane_detect
    import lanebuf_pkg::*;
#(
    parameter int LANE_W = 32,
    parameter int NL     = 4
) (
    input  logic [NL*LANE_W-1:0] flit,
    output fill_e                fill
);
    logic [NL-1:1] is_zero;
    logic [NL-1:1] is_ones;

    // One zero detector and one ones detector for each upper lane.
    for (genvar g = 1; g < NL; g++) begin : g_det
        assign is_zero[g] = ~|flit[g*LANE_W +: LANE_W];
        assign is_ones[g] = &flit[g*LANE_W +: LANE_W];
    end

    assign fill = pick_fill(&is_zero, &is_ones);
endmodule

// File: rtl/lane_bank.sv
module lane_bank #(
    parameter int LANE_W = 32,
    parameter int DEPTH  = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [LANE_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [LANE_W-1:0] rdata
);
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    // The read port is quiet (all zero) when this lane is gated off.
    assign rdata = re ? cells[raddr] : '0;
endmodule

// File: rtl/lane_buffer.sv
module lane_buffer
    import lanebuf_pkg::*;
#(
    parameter int FW  = FLIT_W,
    parameter int NL  = N_LANE,
    parameter int DEP = DEPTH,
    localparam int LW = FW / NL,
    localparam int AW = $clog2(DEP),
    localparam int CW = $clog2(DEP + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [FW-1:0] wr_data,
    output logic          rd_valid,
    input  logic          rd_ready,
    output logic [FW-1:0] rd_data,
    output logic [NL-1:0] wr_lane_en,
    output logic [NL-1:0] rd_lane_en
);
    localparam logic [NL-1:0] MASK_SHORT = NL'(1);
    localparam logic [NL-1:0] MASK_FULL  = '1;

    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] occ;
    fill_e         tag_mem [DEP];
    fill_e         in_fill, head_fill;
    logic          wr_fire, load;
    logic [FW-1:0] bank_q, rebuilt;
    logic [FW-1:0] out_data;
    logic          out_valid;

    lane_detect #(.LANE_W(LW), .NL(NL)) u_detect (
        .flit (wr_data),
        .fill (in_fill)
    );

    assign wr_ready  = (occ != CW'(DEP));
    assign wr_fire   = wr_valid && wr_ready;
    assign load      = (occ != '0) && (!out_valid || rd_ready);
    assign head_fill = tag_mem[rptr];

    assign wr_lane_en = !wr_fire ? '0 : (in_fill == FILL_FULL ? MASK_FULL : MASK_SHORT);
    assign rd_lane_en = !load    ? '0 : (head_fill == FILL_FULL ? MASK_FULL : MASK_SHORT);

    // One storage bank per lane. All banks share the entry index.
    for (genvar g = 0; g < NL; g++) begin : g_lane
        lane_bank #(.LANE_W(LW), .DEPTH(DEP)) u_bank (
            .clk   (clk),
            .we    (wr_lane_en[g]),
            .waddr (wptr),
            .wdata (wr_data[g*LW +: LW]),
            .re    (rd_lane_en[g]),
            .raddr (rptr),
            .rdata (bank_q[g*LW +: LW])
        );
        // Lanes that were gated off are rebuilt from the stored fill tag.
        if (g == 0) begin : g_low
            assign rebuilt[LW-1:0] = bank_q[LW-1:0];
        end else begin : g_up
            assign rebuilt[g*LW +: LW] =
                (head_fill == FILL_FULL) ? bank_q[g*LW +: LW] :
                (head_fill == FILL_ONES) ? {LW{1'b1}} : {LW{1'b0}};
        end
    end

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEP - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (wr_fire) tag_mem[wptr] <= in_fill;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr      <= '0;
            rptr      <= '0;
            occ       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            if (wr_fire) wptr <= bump(wptr);
            if (load)    rptr <= bump(rptr);
            occ <= occ + CW'(wr_fire) - CW'(load);
            if (load) begin
                out_valid <= 1'b1;
                out_data  <= rebuilt;
            end else if (rd_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    assign rd_valid = out_valid;
    assign rd_data  = out_data;

    // R7
    occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= CW'(DEP));

    // R7
    occ_step_chk: assert property (@(posedge clk) disable iff (rst)
        (occ == $past(occ)) || (occ == $past(occ) + CW'(1)) || (occ + CW'(1) == $past(occ)));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

    // R9
    out_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> $past(occ) != '0);

    // R3
    short_tag_chk: assert property (@(posedge clk) disable iff (rst)
        wr_fire && in_fill != FILL_FULL |=> tag_mem[$past(wptr)] != FILL_FULL);
endmodule

// File: tb/lane_buffer_bench.sv
module lane_buffer_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_valid = 1'b0;
    logic         rd_ready = 1'b0;
    logic [127:0] wr_data = '0;
    logic         wr_ready, rd_valid;
    logic [127:0] rd_data;
    logic [3:0]   wr_lane_en, rd_lane_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_buffer u_lane_buffer (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .wr_lane_en(wr_lane_en), .rd_lane_en(rd_lane_en)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [127:0] sb [$];
    logic         prev_v = 1'b0, prev_r = 1'b0;
    logic [127:0] prev_d = '0;

    function automatic logic [3:0] exp_mask(input logic [127:0] d);
        if (d[127:32] == 96'd0 || &d[127:32]) return 4'b0001;
        return 4'b1111;
    endfunction

    function automatic string kind_req(input logic [127:0] d);
        if (d[127:32] == 96'd0) return "R3";
        if (&d[127:32])        return "R4";
        for (int w = 1; w < 4; w++)
            if (d[w*32 +: 32] == 32'd0 || &d[w*32 +: 32]) return "R10";
        return "R5";
    endfunction

    function automatic logic [127:0] make_flit(input int kind);
        logic [31:0] lo = $urandom;
        case (kind % 4)
            0: return {$urandom, $urandom, $urandom, lo};
            1: return {96'd0, lo};
            2: return {{96{1'b1}}, lo};
            default: return {32'd0, 32'hFFFF_FFFF, 32'd0, lo};
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: predicts lane enables and pops read flits.
    always @(negedge clk) begin
        if (!rst && !done) begin
            int stored;
            logic [3:0] exp_rd, exp_wr;
            if (prev_v && !prev_r)
                check(rd_valid && rd_data == prev_d, "R8", "held output",
                      {rd_valid, rd_data[126:0]}, {1'b1, prev_d[126:0]});
            stored = sb.size() - (rd_valid ? 1 : 0);
            exp_rd = 4'b0000;
            if (stored > 0 && (!rd_valid || rd_ready))
                exp_rd = exp_mask(sb[rd_valid ? 1 : 0]);
            check(rd_lane_en == exp_rd, "R6", "rd_lane_en",
                  128'(rd_lane_en), 128'(exp_rd));
            if (rd_valid && rd_ready) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2", "unexpected flit", rd_data, '0);
                end else begin
                    check(rd_data == sb[0], "R2", "order/data", rd_data, sb[0]);
                    check(rd_data == sb[0], kind_req(sb[0]), "rebuilt data", rd_data, sb[0]);
                    void'(sb.pop_front());
                end
            end
            if (wr_valid && wr_ready) begin
                exp_wr = exp_mask(wr_data);
                check(wr_lane_en == exp_wr, kind_req(wr_data), "wr_lane_en",
                      128'(wr_lane_en), 128'(exp_wr));
                sb.push_back(wr_data);
            end else begin
                check(wr_lane_en == 4'b0000, "R5", "idle wr_lane_en",
                      128'(wr_lane_en), 128'd0);
            end
            prev_v = rd_valid;
            prev_r = rd_ready;
            prev_d = rd_data;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        int accepted;
        logic [127:0] f;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        check(!rd_valid && wr_ready && wr_lane_en == 0 && rd_lane_en == 0, "R1",
              "reset state", {rd_valid, wr_ready, wr_lane_en, rd_lane_en}, {1'b0, 1'b1, 8'd0});
        step();
        rst = 1'b0;
        @(negedge clk);
        // R1 after release
        check(!rd_valid && wr_ready, "R1", "post-reset", {rd_valid, wr_ready}, 2'b01);

        // R9: one-cycle latency from write into an empty queue
        f = make_flit(0);
        step();
        wr_valid = 1'b1;
        wr_data  = f;
        step();
        wr_valid = 1'b0;
        @(negedge clk);
        check(!rd_valid, "R9", "early rd_valid", 128'(rd_valid), 128'd0);
        @(negedge clk);
        check(rd_valid && rd_data == f, "R9", "rd_valid after one cycle",
              rd_data, f);
        step();
        rd_ready = 1'b1;
        step();
        rd_ready = 1'b0;

        // R7: reader stalled, offer 20 flits, expect 9 accepted
        accepted = 0;
        for (int i = 0; i < 20; i++) begin
            wr_valid = 1'b1;
            wr_data  = make_flit(i);
            @(negedge clk);
            if (wr_ready) accepted++;
            step();
        end
        wr_valid = 1'b0;
        check(accepted == 9, "R7", "accepted with stalled reader",
              128'(accepted), 128'd9);
        @(negedge clk);
        check(!wr_ready, "R7", "wr_ready when full", 128'(wr_ready), 128'd0);

        // Drain with an irregular reader (exercises R8 holds)
        for (int i = 0; i < 200 && sb.size() > 0; i++) begin
            step();
            rd_ready = $urandom_range(0, 1);
        end

        // Mixed traffic
        for (int i = 0; i < 600; i++) begin
            step();
            wr_valid = $urandom_range(0, 2) != 0;
            wr_data  = make_flit($urandom_range(0, 3));
            rd_ready = $urandom_range(0, 3) != 0;
        end
        step();
        wr_valid = 1'b0;
        rd_ready = 1'b1;
        for (int i = 0; i < 40 && sb.size() > 0; i++) step();
        check(sb.size() == 0, "R2", "queue drained", 128'(sb.size()), 128'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule